// File: doc/BRIEF.md
# Mode-banked register file with exception entry

This block holds the architectural registers of a 32-bit processor: sixteen visible general registers (r13 as stack pointer, r14 as link register, r15 as program counter) and a current status word. Stack pointer and link register have a separate copy in each exception mode. Fast-interrupt mode also has its own copies of r8 to r12. Each exception mode has one saved status word. The register seen at a given index follows the mode field of the current status word.

Exception requests come in as a seven-bit vector. When a request is taken, a single clock edge switches the mode and sets the interrupt disables. In that same edge the old status goes to the saved status word of the target mode, the supplied return address goes to that mode's link register, and the program counter is loaded with the vector address. A return strobe loads the program counter and, in the same edge, copies the saved status of the current mode back into the current status word. The surrounding pipeline uses one read port, one write port and a direct status write.

Top module: `banked_regfile`

## Requirements
- R1: While rst_n is low, one clock edge sets the status low byte to 0xD3, sets pc to the vector base and clears vec_valid. 0xD3 means supervisor mode 10011 in bits [4:0], IRQ disable in bit 7 and FIQ disable in bit 6. General registers reset to zero.
- R2: rd_data shows the register at rd_idx in the current mode's view, combinationally.
  - r0 to r7 and r15 are shared by all modes.
  - r8 to r12 have one copy for FIQ mode (10001) and one copy for all other modes.
  - r13 and r14 have one copy each for FIQ (10001), IRQ (10010), supervisor (10011), abort (10111) and undefined (11011). User (10000), system (11111) and any other encoding share one further copy.
- R3: With wr_en high, wr_data is written at the next edge into the register at wr_idx in the current mode's view. Index 15 writes the program counter.
- R4: exc_req bits are reset (0), data abort (1), FIQ (2), IRQ (3), prefetch abort (4), undefined (5) and software interrupt (6). When several are active, the lowest-numbered one that is not masked is taken.
- R5: An FIQ request is ignored while status bit 6 is set. An IRQ request is ignored while status bit 7 is set. In both cases no exception is taken and the state is unchanged.
- R6: A taken exception moves to its target mode at the next edge. The targets are supervisor for reset and software interrupt, abort for both aborts, undefined, IRQ and FIQ. The old status goes to the target mode's saved status word and ret_addr goes to the target mode's r14. A reset request saves nothing.
- R7: Every taken exception sets status bit 7. FIQ, IRQ and reset also set bit 6. The other exceptions keep bit 6.
- R8: On a taken exception, pc becomes the base plus the offset of that exception. The base is 0xFFFF0000 when hi_vec is high and 0 otherwise. The offsets are reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18 and FIQ 0x1C. vec_valid is high for the one cycle after each taken exception.
- R9: With eret high, pc takes wr_data at the next edge. In the same edge the status takes the saved status word of the current mode. In user or system mode the status is left unchanged.
- R10: In a cycle where an exception is taken, wr_en, psr_we and eret have no effect.
- R11: With psr_we high, and eret low, the status word takes psr_wdata at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_idx | input | 4 | Read register index |
| rd_data | output | 32 | Read data in the current mode's view |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data, also the return target for eret |
| psr_we | input | 1 | Status write strobe |
| psr_wdata | input | 32 | Status write data |
| eret | input | 1 | Return strobe that restores the saved status |
| exc_req | input | 7 | Exception requests, bit map as in R4 |
| ret_addr | input | 32 | Return address saved to the target mode's r14 |
| hi_vec | input | 1 | Selects the high vector base |
| cpsr | output | 32 | Current status word |
| pc | output | 32 | Program counter (r15) |
| vec_valid | output | 1 | High for one cycle after a taken exception |

## Verification
Every stimulus is applied at a falling edge. Its results appear one rising edge later: the status word, pc, vec_valid and the read data of the post-edge view. The driver pushes each expected value into a queue stamped with the next edge's cycle number. The monitor pops and compares items only 2 ns after that edge, so no check can land on a stale or in-flight value. Read data has no register of its own. It is therefore sampled in the same cycle as the state update it depends on, with rd_idx held from the stimulus.

// File: rtl/banked_regfile.sv
module banked_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  rd_idx,
  output logic [31:0] rd_data,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic        psr_we,
  input  logic [31:0] psr_wdata,
  input  logic        eret,
  input  logic [6:0]  exc_req,
  input  logic [31:0] ret_addr,
  input  logic        hi_vec,
  output logic [31:0] cpsr,
  output logic [31:0] pc,
  output logic        vec_valid
);
  localparam logic [4:0] M_FIQ = 5'b10001, M_IRQ = 5'b10010, M_SVC = 5'b10011,
                         M_ABT = 5'b10111, M_UND = 5'b11011;
  localparam int NB = 6;

  logic [31:0] low_q [8];
  logic [31:0] hu_q  [5];
  logic [31:0] hf_q  [5];
  logic [31:0] sp_q  [NB];
  logic [31:0] lr_q  [NB];
  logic [31:0] spsr_q[NB];

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   return 3'd1;
      M_IRQ:   return 3'd2;
      M_SVC:   return 3'd3;
      M_ABT:   return 3'd4;
      M_UND:   return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  logic [2:0]  cb, nb;
  logic        in_fiq;
  logic [3:0]  rd_off, wr_off;
  assign cb     = bank_of(cpsr[4:0]);
  assign in_fiq = (cb == 3'd1);
  assign rd_off = rd_idx - 4'd8;
  assign wr_off = wr_idx - 4'd8;

  always_comb begin
    if (rd_idx < 4'd8)       rd_data = low_q[rd_idx[2:0]];
    else if (rd_idx < 4'd13) rd_data = in_fiq ? hf_q[rd_off[2:0]] : hu_q[rd_off[2:0]];
    else if (rd_idx == 4'd13) rd_data = sp_q[cb];
    else if (rd_idx == 4'd14) rd_data = lr_q[cb];
    else                      rd_data = pc;
  end

  logic        take, is_rst, set_f;
  logic [4:0]  tmode;
  logic [4:0]  toff;
  logic [31:0] base, ncpsr;
  assign base = hi_vec ? 32'hFFFF0000 : 32'h0;

  always_comb begin
    take = 1'b1; is_rst = 1'b0; set_f = 1'b0; tmode = M_SVC; toff = 5'h00;
    if (exc_req[0])                    begin is_rst = 1'b1; set_f = 1'b1; end
    else if (exc_req[1])               begin tmode = M_ABT; toff = 5'h10; end
    else if (exc_req[2] && !cpsr[6])   begin tmode = M_FIQ; toff = 5'h1C; set_f = 1'b1; end
    else if (exc_req[3] && !cpsr[7])   begin tmode = M_IRQ; toff = 5'h18; set_f = 1'b1; end
    else if (exc_req[4])               begin tmode = M_ABT; toff = 5'h0C; end
    else if (exc_req[5])               begin tmode = M_UND; toff = 5'h04; end
    else if (exc_req[6])               begin tmode = M_SVC; toff = 5'h08; end
    else take = 1'b0;
  end

  assign nb    = bank_of(tmode);
  assign ncpsr = {cpsr[31:8], 1'b1, set_f | cpsr[6], cpsr[5], tmode};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) low_q[i] <= '0;
      for (int i = 0; i < 5; i++) begin hu_q[i] <= '0; hf_q[i] <= '0; end
      for (int i = 0; i < NB; i++) begin sp_q[i] <= '0; lr_q[i] <= '0; spsr_q[i] <= '0; end
      cpsr      <= 32'h000000D3;
      pc        <= base;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= take;
      if (take) begin
        cpsr <= ncpsr;
        pc   <= base | {27'd0, toff};
        if (!is_rst) begin
          spsr_q[nb] <= cpsr;
          lr_q[nb]   <= ret_addr;
        end
      end else if (eret) begin
        pc <= wr_data;
        if (cb != 3'd0) cpsr <= spsr_q[cb];
      end else begin
        if (psr_we) cpsr <= psr_wdata;
        if (wr_en) begin
          if (wr_idx < 4'd8) low_q[wr_idx[2:0]] <= wr_data;
          else if (wr_idx < 4'd13) begin
            if (in_fiq) hf_q[wr_off[2:0]] <= wr_data;
            else        hu_q[wr_off[2:0]] <= wr_data;
          end
          else if (wr_idx == 4'd13) sp_q[cb] <= wr_data;
          else if (wr_idx == 4'd14) lr_q[cb] <= wr_data;
          else                      pc <= wr_data;
        end
      end
    end
  end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [6:0]  exc_req,
  input logic [31:0] cpsr,
  input logic [31:0] pc,
  input logic        vec_valid
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (cpsr[7:0] == 8'hD3 && !vec_valid));

  p_irq_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req == 7'b0001000 && cpsr[7]) |=> !vec_valid);

  p_exc_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (cpsr[4:0] != 5'b10000 && cpsr[4:0] != 5'b11111 && cpsr[7]));

  p_irq_disables_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && cpsr[4:0] == 5'b10010) |-> cpsr[7:6] == 2'b11);

  p_vec_form_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (pc[1:0] == 2'b00 && pc[15:5] == 11'd0 &&
                   (pc[31:16] == 16'h0000 || pc[31:16] == 16'hFFFF)));
endmodule

bind banked_regfile banked_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req),
  .cpsr(cpsr), .pc(pc), .vec_valid(vec_valid)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic clk = 0, rst_n = 0;
  logic [3:0] rd_idx = 0, wr_idx = 0;
  logic [31:0] rd_data, wr_data = 0, psr_wdata = 0, ret_addr = 0, cpsr, pc;
  logic wr_en = 0, psr_we = 0, eret = 0, hi_vec = 0, vec_valid;
  logic [6:0] exc_req = 0;

  always #5 clk = ~clk;

  banked_regfile uut (.*);

  typedef struct { int due; int sel; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  task automatic expect_v(int sel, logic [31:0] v, string tag);
    item_t it;
    it.due = cyc + 1; it.sel = sel; it.exp = v; it.tag = tag;
    q.push_back(it);
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
    #2;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = cpsr;
        1: act = pc;
        2: act = rd_data;
        default: act = {31'd0, vec_valid};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel%0d actual %h expected %h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    wr_en = 0; psr_we = 0; eret = 0; exc_req = 0;
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    step(); rd_idx = 0;
    expect_v(0, 32'hD3, "R1"); expect_v(1, 0, "R1"); expect_v(3, 0, "R1"); expect_v(2, 0, "R1");
    // R3 writes in supervisor view
    step(); wr_en = 1; wr_idx = 13; wr_data = 32'h5005; rd_idx = 13; expect_v(2, 32'h5005, "R3");
    step(); wr_en = 1; wr_idx = 14; wr_data = 32'h1414; rd_idx = 14; expect_v(2, 32'h1414, "R3");
    step(); wr_en = 1; wr_idx = 0;  wr_data = 32'hAA;   rd_idx = 0;  expect_v(2, 32'hAA, "R3");
    // R11 status write to system mode, R2 user/system bank
    step(); psr_we = 1; psr_wdata = 32'h1F; rd_idx = 13;
    expect_v(0, 32'h1F, "R11"); expect_v(2, 0, "R2");
    step(); wr_en = 1; wr_idx = 13; wr_data = 32'h7777; rd_idx = 13; expect_v(2, 32'h7777, "R3");
    step(); wr_en = 1; wr_idx = 8;  wr_data = 32'h88;   rd_idx = 8;  expect_v(2, 32'h88, "R3");
    // R6/R7/R8 IRQ entry, R10 write dropped
    step(); exc_req = 7'b0001000; ret_addr = 32'h1004; wr_en = 1; wr_idx = 0; wr_data = 32'hBEEF; rd_idx = 14;
    expect_v(0, 32'hD2, "R7"); expect_v(1, 32'h18, "R8"); expect_v(3, 1, "R8"); expect_v(2, 32'h1004, "R6");
    step(); rd_idx = 0; expect_v(2, 32'hAA, "R10"); expect_v(3, 0, "R8");
    step(); rd_idx = 8; expect_v(2, 32'h88, "R2");
    // R9 return restores status
    step(); eret = 1; wr_data = 32'h2000; rd_idx = 13;
    expect_v(0, 32'h1F, "R9"); expect_v(1, 32'h2000, "R9"); expect_v(2, 32'h7777, "R2");
    // R5 masked IRQ
    step(); psr_we = 1; psr_wdata = 32'h9F; expect_v(0, 32'h9F, "R11");
    step(); exc_req = 7'b0001000; ret_addr = 32'h3000; rd_idx = 14;
    expect_v(0, 32'h9F, "R5"); expect_v(3, 0, "R5"); expect_v(1, 32'h2000, "R5"); expect_v(2, 0, "R5");
    // R4 data abort wins
    step(); exc_req = 7'b1111110; ret_addr = 32'h4000; rd_idx = 14;
    expect_v(0, 32'h97, "R4"); expect_v(1, 32'h10, "R4"); expect_v(2, 32'h4000, "R6");
    step(); eret = 1; wr_data = 32'h2100; expect_v(0, 32'h9F, "R9"); expect_v(1, 32'h2100, "R9");
    step(); psr_we = 1; psr_wdata = 32'h1F; expect_v(0, 32'h1F, "R11");
    // R4 FIQ beats IRQ, R2 FIQ r8 copy
    step(); exc_req = 7'b0011100; ret_addr = 32'h5000; rd_idx = 8;
    expect_v(0, 32'hD1, "R4"); expect_v(1, 32'h1C, "R8"); expect_v(2, 0, "R2");
    step(); wr_en = 1; wr_idx = 8; wr_data = 32'hF8; rd_idx = 8; expect_v(2, 32'hF8, "R2");
    step(); eret = 1; wr_data = 32'h2200; rd_idx = 8;
    expect_v(0, 32'h1F, "R9"); expect_v(2, 32'h88, "R2");
    // R8 high vectors, software interrupt
    step(); hi_vec = 1; exc_req = 7'b1000000; ret_addr = 32'h6000; rd_idx = 13;
    expect_v(0, 32'h93, "R7"); expect_v(1, 32'hFFFF0008, "R8"); expect_v(2, 32'h5005, "R2");
    step(); rd_idx = 14; expect_v(2, 32'h6000, "R6");
    step(); exc_req = 7'b1100000; ret_addr = 32'h7000;
    expect_v(0, 32'h9B, "R4"); expect_v(1, 32'hFFFF0004, "R8");
    // R10 status write dropped during entry
    step(); exc_req = 7'b0010000; ret_addr = 32'h8000; psr_we = 1; psr_wdata = 32'h1F;
    expect_v(0, 32'h97, "R10"); expect_v(1, 32'hFFFF000C, "R8");
    step(); eret = 1; wr_data = 32'h2300; expect_v(0, 32'h9B, "R9"); expect_v(1, 32'h2300, "R9");
    step(); psr_we = 1; psr_wdata = 32'h1F; expect_v(0, 32'h1F, "R11");
    step(); eret = 1; wr_data = 32'h2400; expect_v(0, 32'h1F, "R9"); expect_v(1, 32'h2400, "R9");
    step(); wr_en = 1; wr_idx = 15; wr_data = 32'h2500; rd_idx = 15;
    expect_v(1, 32'h2500, "R3"); expect_v(2, 32'h2500, "R2");
    // R4 reset request wins, saves nothing
    step(); exc_req = 7'h7F; ret_addr = 32'h9000; rd_idx = 14;
    expect_v(0, 32'hD3, "R4"); expect_v(1, 32'hFFFF0000, "R8"); expect_v(2, 32'h6000, "R6");
    step();
    done = 1;
    finish_run();
  end
endmodule